// File: doc/BRIEF.md
# Capability Tag Cache Controller

This block holds one validity bit, the tag, for every 32-byte data word of memory. The tags are packed into a compressed table in a separate tag memory, at a ratio of 1:256 against the data they describe. Recently used parts of that table are kept in a small 4-way set-associative cache. Each cache line is 1024 tag bits, which covers 32 KiB of data. Misses and evictions move one whole line over the tag memory port in a single transfer.

A client sends one of three operations over a valid/ready port:
- **Fill** returns the four tags of a 128-byte data line.
- **Store** sets a word's tag when a capability is written and clears it when plain data is written.
- **Query** returns the same four tags without bringing the line into the cache. It is meant for sweeps that scan memory for live capabilities.

Only one request is in flight at a time. Every request is answered with a single-cycle response pulse.

Top module: `tag_cache_ctrl`

## Requirements
- R1: A tag index is the data byte address shifted right by 5. A fill (op code 0) returns `rsp_tags`, where bit i is the tag of the word at `(addr & ~127) + 32*i`.
- R2: A store (op code 1) with `req_cap`=1 sets the target word's tag to 1. The store's response carries the four tags after the update.
- R3: A store with `req_cap`=0 to any byte of a 32-byte word clears that word's tag and leaves the other words alone.
- R4: After reset every tag reads 0, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0.
- R5: A query (op code 2) that hits returns the cached bits without any memory traffic. A query that misses does one memory read of the line and never writes memory. It allocates nothing, so the same query misses again.
- R6: Every store marks its line dirty, even when the new tag equals the old one. A dirty victim is written back in one transfer before the refill read of the new line starts.
- R7: Replacement fills invalid ways first, lowest way first. Otherwise a 3-bit tree pseudo-LRU per set picks the victim, and both hits and refills update it.
- R8: `req_ready` is high only when the block is idle. After an accept, no new request is taken until the response. `rsp_valid` is high for exactly one cycle per request.
- R9: A memory request holds `mem_req`, `mem_we` and `mem_addr` stable until `mem_ack`. `mem_addr` is a tag-line address, the data address shifted right by 15.
- R10: The set is the low bits of the tag-line address. Bit `addr[14:5]` of the 1024-bit line holds the tag of that word, so the last word of a 32 KiB region is bit 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_op | input | 2 | 0 fill, 1 store, 2 query |
| req_addr | input | ADDR_W | Data byte address |
| req_cap | input | 1 | Store writes a capability (1) or plain data (0) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_tags | output | 4 | Tags of the addressed 128-byte data line |
| mem_req | output | 1 | Tag memory transfer request |
| mem_we | output | 1 | Transfer is a write-back |
| mem_addr | output | ADDR_W-15 | Tag-line address |
| mem_wdata | output | 1024 | Line written back |
| mem_ack | input | 1 | Transfer done, read data valid |
| mem_rdata | input | 1024 | Line read from tag memory |

## Verification
A store that misses in a set whose victim is dirty sets up two collisions.

First, the write-back and the store's own update act on the same set in one request. Second, the refill data and the new tag bit are written into the way RAM on the same edge as the response is registered.

The bench provokes this by filling a set with dirty lines and then storing a capability to a fifth line. It judges the outcome three ways:
- the order of memory operations seen by the bench's memory model (write, then read);
- the response tags;
- a later read of every line of the set, including the evicted one, which must come back from memory.

// File: rtl/tagc_pkg.sv
package tagc_pkg;
  localparam int WAYS      = 4;
  localparam int WAY_W     = 2;
  localparam int LINE_BITS = 1024;
  localparam int WORD_SH   = 5;
  localparam int LINE_SH   = 15;
  localparam int TIDX_W    = LINE_SH - WORD_SH;
  localparam int GRP_W     = TIDX_W - 2;

  localparam logic [1:0] OP_FILL  = 2'd0;
  localparam logic [1:0] OP_STORE = 2'd1;
  localparam logic [1:0] OP_QUERY = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_WB,
    S_FILL,
    S_QRD
  } tc_state_e;
endpackage

// File: rtl/tagc_way_ram.sv
module tagc_way_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 1024,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/tagc_plru.sv
module tagc_plru
  import tagc_pkg::*;
(
  input  logic [2:0]       bits,
  input  logic [WAY_W-1:0] acc_way,
  output logic [WAY_W-1:0] victim,
  output logic [2:0]       next_bits
);
  // bit0 picks the pair, bit1 the left pair member, bit2 the right one
  always_comb begin
    victim = bits[0] ? {1'b1, bits[2]} : {1'b0, bits[1]};
    next_bits = bits;
    next_bits[0] = ~acc_way[1];
    if (acc_way[1]) next_bits[2] = ~acc_way[0];
    else            next_bits[1] = ~acc_way[0];
  end
endmodule

// File: rtl/tag_cache_ctrl.sv
module tag_cache_ctrl
  import tagc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 64,
  localparam int LADDR_W = ADDR_W - LINE_SH
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_op,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_cap,
  output logic                 rsp_valid,
  output logic [3:0]           rsp_tags,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [LADDR_W-1:0]   mem_addr,
  output logic [LINE_BITS-1:0] mem_wdata,
  input  logic                 mem_ack,
  input  logic [LINE_BITS-1:0] mem_rdata
);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = LADDR_W - SET_W;

  tc_state_e                  state;
  logic [1:0]                 op_q;
  logic                       cap_q;
  logic [ADDR_W-1:WORD_SH]    addr_q;
  logic [WAYS-1:0]            vld   [SETS];
  logic [WAYS-1:0]            dirty [SETS];
  logic [TAG_W-1:0]           tagr  [SETS][WAYS];
  logic [2:0]                 plru  [SETS];
  logic [WAY_W-1:0]           victim_q;

  logic                       unused_lo;
  assign unused_lo = ^req_addr[WORD_SH-1:0];

  logic [SET_W-1:0]           set_q, ram_addr;
  logic [TAG_W-1:0]           tag_q;
  logic [TIDX_W-1:0]          tidx_q;
  logic [GRP_W-1:0]           grp_q;
  assign set_q  = addr_q[LINE_SH +: SET_W];
  assign tag_q  = addr_q[ADDR_W-1 -: TAG_W];
  assign tidx_q = addr_q[LINE_SH-1:WORD_SH];
  assign grp_q  = addr_q[LINE_SH-1:WORD_SH+2];
  assign ram_addr = (state == S_IDLE) ? req_addr[LINE_SH +: SET_W] : set_q;

  // way storage, one inferred RAM per way
  logic [LINE_BITS-1:0] ram_q [WAYS];
  logic [WAYS-1:0]      ram_we;
  logic [LINE_BITS-1:0] wr_line, src_line;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    tagc_way_ram #(.DEPTH(SETS), .WIDTH(LINE_BITS)) u_ram (
      .clk   (clk),
      .we    (ram_we[g]),
      .addr  (ram_addr),
      .wdata (wr_line),
      .q     (ram_q[g])
    );
  end

  // hit detection and victim choice
  logic             hit_any;
  logic [WAY_W-1:0] hit_way, victim, plru_vict, acc_way;
  logic [2:0]       plru_next;

  always_comb begin
    hit_any = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!hit_any && vld[set_q][w] && tagr[set_q][w] == tag_q) begin
        hit_any = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  assign acc_way = (state == S_FILL) ? victim_q : hit_way;

  tagc_plru u_plru (
    .bits      (plru[set_q]),
    .acc_way   (acc_way),
    .victim    (plru_vict),
    .next_bits (plru_next)
  );

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = plru_vict;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !vld[set_q][w]) begin
        found  = 1'b1;
        victim = WAY_W'(w);
      end
    end
  end

  // line update path shared by hit store and refill
  always_comb begin
    src_line = (state == S_LOOK) ? ram_q[hit_way] : mem_rdata;
    wr_line  = src_line;
    if (op_q == OP_STORE) wr_line[tidx_q] = cap_q;
    for (int w = 0; w < WAYS; w++) begin
      ram_we[w] = (state == S_LOOK && hit_any && op_q == OP_STORE && hit_way == WAY_W'(w)) ||
                  (state == S_FILL && mem_ack && victim_q == WAY_W'(w));
    end
  end

  assign req_ready = (state == S_IDLE);
  assign mem_req   = (state == S_WB) || (state == S_FILL) || (state == S_QRD);
  assign mem_we    = (state == S_WB);
  assign mem_addr  = (state == S_WB) ? {tagr[set_q][victim_q], set_q} : addr_q[ADDR_W-1:LINE_SH];
  assign mem_wdata = ram_q[victim_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      op_q      <= OP_FILL;
      cap_q     <= 1'b0;
      addr_q    <= '0;
      victim_q  <= '0;
      rsp_valid <= 1'b0;
      rsp_tags  <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld[s]   <= '0;
        dirty[s] <= '0;
        plru[s]  <= '0;
        for (int w = 0; w < WAYS; w++) tagr[s][w] <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          op_q   <= req_op;
          cap_q  <= req_cap;
          addr_q <= req_addr[ADDR_W-1:WORD_SH];
          state  <= S_LOOK;
        end
        S_LOOK: begin
          if (hit_any) begin
            rsp_valid   <= 1'b1;
            rsp_tags    <= wr_line[{grp_q, 2'b00} +: 4];
            plru[set_q] <= plru_next;
            if (op_q == OP_STORE) dirty[set_q][hit_way] <= 1'b1;
            state <= S_IDLE;
          end else if (op_q == OP_QUERY) begin
            state <= S_QRD;
          end else begin
            victim_q <= victim;
            state    <= (vld[set_q][victim] && dirty[set_q][victim]) ? S_WB : S_FILL;
          end
        end
        S_WB: if (mem_ack) state <= S_FILL;
        S_FILL: if (mem_ack) begin
          vld[set_q][victim_q]   <= 1'b1;
          dirty[set_q][victim_q] <= (op_q == OP_STORE);
          tagr[set_q][victim_q]  <= tag_q;
          plru[set_q]            <= plru_next;
          rsp_valid              <= 1'b1;
          rsp_tags               <= wr_line[{grp_q, 2'b00} +: 4];
          state                  <= S_IDLE;
        end
        S_QRD: if (mem_ack) begin
          rsp_valid <= 1'b1;
          rsp_tags  <= mem_rdata[{grp_q, 2'b00} +: 4];
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tagc_chk.sv
module tagc_chk #(
  parameter int ADDR_W = 32,
  localparam int LADDR_W = ADDR_W - 15
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic [1:0]         req_op,
  input logic               rsp_valid,
  input logic               mem_req,
  input logic               mem_we,
  input logic [LADDR_W-1:0] mem_addr,
  input logic               mem_ack
);
  logic qry_q;

  always_ff @(posedge clk) begin
    if (rst) qry_q <= 1'b0;
    else if (req_valid && req_ready) qry_q <= (req_op == 2'd2);
  end

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R8
  one_req_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R5
  query_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && qry_q) |-> !mem_we);
endmodule

bind tag_cache_ctrl tagc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .rsp_valid (rsp_valid),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_ack   (mem_ack)
);

// File: tb/tag_cache_ctrl_test.sv
module tag_cache_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int SETS       = 2;
  localparam int LADDR_W    = ADDR_W - 15;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               req_valid = 1'b0;
  logic               req_ready;
  logic [1:0]         req_op = 2'd0;
  logic [ADDR_W-1:0]  req_addr = '0;
  logic               req_cap = 1'b0;
  logic               rsp_valid;
  logic [3:0]         rsp_tags;
  logic               mem_req, mem_we;
  logic [LADDR_W-1:0] mem_addr;
  logic [1023:0]      mem_wdata;
  logic               mem_ack = 1'b0;
  logic [1023:0]      mem_rdata = '0;

  tag_cache_ctrl #(.ADDR_W(ADDR_W), .SETS(SETS)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_cap(req_cap),
    .rsp_valid(rsp_valid), .rsp_tags(rsp_tags), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int n_rd = 0, n_wr = 0, last_rd = -1, lat = 0;
  int busy_bad = 0, pulse_bad = 0;
  bit op_log[$];
  logic [1023:0] tmem [int unsigned];
  bit ref_tag [int unsigned];

  // tag memory model: answers each request after a few cycles
  always @(negedge clk) begin
    if (mem_req && req_ready) busy_bad++;
    if (rst) begin
      mem_ack = 1'b0;
      lat = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      lat++;
      if (lat == 3) begin
        lat = 0;
        if (mem_we) begin
          tmem[int'(mem_addr)] = mem_wdata;
          n_wr++;
          op_log.push_back(1'b1);
        end else begin
          mem_rdata = tmem.exists(int'(mem_addr)) ? tmem[int'(mem_addr)] : '0;
          n_rd++;
          last_rd = int'(mem_addr);
          op_log.push_back(1'b0);
        end
        mem_ack = 1'b1;
      end
    end
  end

  task automatic check(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_tags(input logic [31:0] a);
    logic [3:0] t;
    for (int i = 0; i < 4; i++) begin
      int unsigned k;
      k = ((a >> 7) << 2) + i;
      t[i] = ref_tag.exists(k) ? ref_tag[k] : 1'b0;
    end
    return t;
  endfunction

  task automatic do_req(input logic [1:0] op, input logic [31:0] a, input logic cap,
                        output logic [3:0] t);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_cap = cap;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 2000) begin @(negedge clk); n++; end
    t = rsp_tags;
    @(negedge clk);
    if (rsp_valid) pulse_bad++;
    if (op == 2'd1) ref_tag[a >> 5] = cap;
  endtask

  function automatic logic [31:0] la(input int line, input int off);
    return (32'(line) << 15) + 32'(off);
  endfunction

  task automatic t_reset();
    logic [3:0] t;
    check("R4 ready after reset", int'(req_ready), 1);
    check("R4 no response after reset", int'(rsp_valid), 0);
    check("R4 no memory request after reset", int'(mem_req), 0);
    do_req(2'd0, la(0, 0), 1'b0, t);
    check("R4 tags zero after reset", int'(t), 0);
  endtask

  task automatic t_cap_store();
    logic [3:0] t;
    do_req(2'd1, la(0, 'h40), 1'b1, t);
    check("R2 store response shows set tag", int'(t), 4'b0100);
    do_req(2'd0, la(0, 'h40), 1'b0, t);
    check("R1 fill returns word 2 tag", int'(t), 4'b0100);
    do_req(2'd1, la(0, 'h7FE0), 1'b1, t);
    do_req(2'd0, la(0, 'h7F80), 1'b0, t);
    check("R10 last word of region is tag bit 1023", int'(t), 4'b1000);
  endtask

  task automatic t_plain_store();
    logic [3:0] t;
    do_req(2'd1, la(0, 'h20), 1'b1, t);
    do_req(2'd1, la(0, 'h5D), 1'b0, t);
    do_req(2'd0, la(0, 'h00), 1'b0, t);
    check("R3 plain store clears only its word", int'(t), 4'b0010);
  endtask

  task automatic t_query();
    logic [3:0] t;
    int r0;
    logic [1023:0] pre;
    r0 = n_rd;
    do_req(2'd2, la(0, 0), 1'b0, t);
    check("R5 query hit value", int'(t), int'(exp_tags(la(0, 0))));
    check("R5 query hit makes no memory read", n_rd - r0, 0);
    pre = '0;
    pre[4*3 +: 4] = 4'b1001;
    tmem[20] = pre;
    ref_tag[(la(20, 'h180)) >> 5] = 1'b1;
    ref_tag[(la(20, 'h1E0)) >> 5] = 1'b1;
    r0 = n_rd;
    op_log.delete();
    do_req(2'd2, la(20, 'h180), 1'b0, t);
    check("R5 query miss returns memory tags", int'(t), 4'b1001);
    check("R9 query miss reads tag line 20", last_rd, 20);
    do_req(2'd2, la(20, 'h180), 1'b0, t);
    check("R5 query miss does not allocate", n_rd - r0, 2);
    check("R5 query never writes memory", int'(op_log.size() == 2 && !op_log[0] && !op_log[1]), 1);
  endtask

  task automatic t_evict_wb();
    logic [3:0] t;
    int w0;
    do_req(2'd1, la(2, 'h80), 1'b1, t);
    do_req(2'd1, la(4, 'h100), 1'b1, t);
    do_req(2'd1, la(6, 'h60), 1'b1, t);
    w0 = n_wr;
    op_log.delete();
    do_req(2'd1, la(8, 'h20), 1'b1, t);
    check("R2 store miss response merged", int'(t), 4'b0010);
    check("R6 dirty victim written back once", n_wr - w0, 1);
    check("R6 write-back precedes refill", int'(op_log.size() == 2 && op_log[0] && !op_log[1]), 1);
    for (int l = 0; l <= 8; l += 2) begin
      do_req(2'd0, la(l, 0), 1'b0, t);
      check("R6 set contents after eviction", int'(t), int'(exp_tags(la(l, 0))));
      do_req(2'd0, la(l, 'h80), 1'b0, t);
      check("R6 set contents after eviction", int'(t), int'(exp_tags(la(l, 'h80))));
    end
    check("R8 ready low while memory busy", busy_bad, 0);
  endtask

  task automatic t_same_value();
    logic [3:0] t;
    int w0;
    do_req(2'd1, la(1, 0), 1'b0, t);
    do_req(2'd0, la(3, 0), 1'b0, t);
    do_req(2'd0, la(5, 0), 1'b0, t);
    do_req(2'd0, la(7, 0), 1'b0, t);
    w0 = n_wr;
    do_req(2'd0, la(9, 0), 1'b0, t);
    check("R6 equal-value store still dirties line", n_wr - w0, 1);
    check("R7 invalid ways filled first then tree victim", int'(tmem.exists(1)), 1);
  endtask

  task automatic t_plru();
    logic [3:0] t;
    int r0;
    do_req(2'd0, la(3, 0), 1'b0, t);
    do_req(2'd0, la(11, 0), 1'b0, t);
    r0 = n_rd;
    do_req(2'd0, la(3, 0), 1'b0, t);
    do_req(2'd0, la(7, 0), 1'b0, t);
    do_req(2'd0, la(9, 0), 1'b0, t);
    check("R7 recently used lines kept", n_rd - r0, 0);
    do_req(2'd0, la(5, 0), 1'b0, t);
    check("R7 tree pseudo-LRU evicted line 5", n_rd - r0, 1);
    check("R8 single-cycle response pulse", pulse_bad, 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cap_store();
    t_plain_store();
    t_query();
    t_evict_wb();
    t_same_value();
    t_plru();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule